// File: doc/BRIEF.md
# Bit-Serial Stream-Cipher Authenticator

This block is the message-authentication half of a bit-serial stream cipher. An upstream keystream generator supplies one pre-output bit per clock, with a valid flag. After a `start` pulse the block spends 128 valid bits filling its two 64-bit registers. The first 64 bits go to the accumulator and the next 64 go to the authentication shift register. From then on the bits alternate. A keystream bit encrypts one message bit, and the authentication bit that follows it advances the MAC state.

The message bit is taken in the same cycle as its keystream bit, and `msg_take` marks that cycle. The ciphertext bit appears one clock later. During the following authentication step, a message bit of one folds the current shift register into the accumulator, and the new authentication bit is then shifted in. The caller flags the last message bit with `msg_last`. Once that bit's authentication step is done, `done` pulses and `tag` holds the final accumulator. A parameter selects an extra register stage on the accumulator update path, which moves the accumulator update and `done` one clock later.

`rst_n` is asynchronous and active low. It is expected to be released synchronously to `clk`.

Top module: `auth_mac`

## Requirements
- R1: While `rst_n` is low and after its release, `ct_vld`, `done` and `msg_take` are 0. The block stays idle, with no outputs changing, until `start` is seen.
- R2: After `start`, the first 64 valid pre-output bits load the accumulator. The k-th of these bits (k = 0..63) lands in accumulator bit k, which is `tag[k]`.
- R3: The next 64 valid bits load the shift register. The k-th of these bits lands in shift-register bit k.
- R4: After loading, the valid bits with even index (counting from 0) are keystream bits. In such a cycle `msg_take` is 1, `msg_bit` is consumed, and one clock later `ct_vld` is 1 with `ct_bit` = `msg_bit` XOR the keystream bit.
- R5: Valid bits with odd index are authentication bits. If the message bit taken in the preceding keystream cycle was 1, the accumulator is XORed with the shift-register value from before that step. The shift register then moves every bit k to bit k-1 and places the authentication bit in bit 63.
- R6: A message bit of 0 leaves the accumulator unchanged.
- R7: If `msg_last` is 1 in a keystream cycle, the authentication step after it is the final one. The block pulses `done` for one clock with `tag` equal to the final accumulator, keeps `tag` unchanged, and returns to idle.
- R8: A cycle with `pre_vld` at 0 advances nothing: no register changes and no slot is consumed.
- R9: `start` restarts loading from any state. The pre-output bit offered in the `start` cycle is ignored, and any pending accumulator update or `done` is dropped.
- R10: With `pre_vld` held at 1, one message bit is processed every two clocks.
- R11: With `PIPE`=0, `done` and the accumulator update appear one clock after the final authentication cycle. With `PIPE`=1, both appear two clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new session (register loading) |
| pre_vld | input | 1 | Pre-output bit is valid this cycle |
| pre_bit | input | 1 | Pre-output bit from the generator |
| msg_bit | input | 1 | Message bit, consumed when `msg_take` is 1 |
| msg_last | input | 1 | Marks the consumed message bit as the last one |
| msg_take | output | 1 | This cycle consumes `msg_bit` (keystream slot) |
| ct_vld | output | 1 | `ct_bit` is valid |
| ct_bit | output | 1 | Ciphertext bit |
| done | output | 1 | One-clock pulse: `tag` is final |
| tag | output | 64 | Accumulator value |

## Verification
The bench targets the load boundaries. An all-zero message must return exactly the first 64 loaded bits as the tag, and a design that loads in the wrong order or loads into the wrong register gets a different tag. A single-one message must return the first 64 bits XOR the next 64. A design that shifts the register before folding it, or that swaps the even and odd slot roles, breaks this. Random valid gaps, restarts in the middle of a session, and both pipeline settings are compared clock by clock against a behavioural model. A design that advances on an invalid cycle, keeps a stale pending update across `start`, or mistimes `done` then diverges on the tag or on the pulse cycle.

// File: rtl/auth_mac_pkg.sv
package auth_mac_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LDA  = 3'd1,
    PH_LDR  = 3'd2,
    PH_KS   = 3'd3,
    PH_AU   = 3'd4
  } phase_t;
endpackage

// File: rtl/auth_mac_ctrl.sv
module auth_mac_ctrl
  import auth_mac_pkg::*;
#(
  parameter int W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pre_vld,
  input  logic msg_last,
  output logic load_acc,
  output logic load_sreg,
  output logic ks_slot,
  output logic auth_slot,
  output logic final_auth
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CMAX = CW'(W - 1);

  phase_t ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic last_q, last_d;
  logic act;

  assign act        = pre_vld & ~start;
  assign load_acc   = act & (ph_q == PH_LDA);
  assign load_sreg  = act & (ph_q == PH_LDR);
  assign ks_slot    = act & (ph_q == PH_KS);
  assign auth_slot  = act & (ph_q == PH_AU);
  assign final_auth = auth_slot & last_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (start) begin
      ph_d   = PH_LDA;
      cnt_d  = '0;
      last_d = 1'b0;
    end else if (pre_vld) begin
      unique case (ph_q)
        PH_LDA: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CMAX) ph_d = PH_LDR;
        end
        PH_LDR: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CMAX) ph_d = PH_KS;
        end
        PH_KS: begin
          last_d = msg_last;
          ph_d   = PH_AU;
        end
        PH_AU:   ph_d = last_q ? PH_IDLE : PH_KS;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !start) |=> (ph_q == PH_IDLE));
  // R4
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_acc, load_sreg, ks_slot, auth_slot}));
  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_vld && !start) |=> ($stable(ph_q) && $stable(cnt_q)));
endmodule

// File: rtl/auth_mac_acc.sv
module auth_mac_acc #(
  parameter int W    = 64,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_en,
  input  logic         load_bit,
  input  logic         upd_en,
  input  logic [W-1:0] term_in,
  input  logic         final_in,
  output logic [W-1:0] acc,
  output logic         done
);
  logic [W-1:0] acc_q, acc_d;
  logic         done_q, done_d;

  assign acc  = acc_q;
  assign done = done_q;

  generate
    if (PIPE) begin : g_pipe
      logic [W-1:0] term_q, term_d;
      logic         tvld_q, tvld_d, fin_q, fin_d;

      always_comb begin
        term_d = term_q;
        tvld_d = upd_en & ~clr;
        fin_d  = final_in & ~clr;
        if (upd_en) term_d = term_in;
        acc_d  = acc_q;
        if (clr)         acc_d = acc_q;
        else if (load_en) acc_d = {load_bit, acc_q[W-1:1]};
        else if (tvld_q)  acc_d = acc_q ^ term_q;
        done_d = fin_q & ~clr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          term_q <= '0;
          tvld_q <= 1'b0;
          fin_q  <= 1'b0;
        end else begin
          term_q <= term_d;
          tvld_q <= tvld_d;
          fin_q  <= fin_d;
        end
      end

      // R11
      pipe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(final_in, 2));
    end else begin : g_direct
      always_comb begin
        acc_d = acc_q;
        if (clr)          acc_d = acc_q;
        else if (load_en) acc_d = {load_bit, acc_q[W-1:1]};
        else if (upd_en)  acc_d = acc_q ^ term_in;
        done_d = final_in & ~clr;
      end

      // R11
      direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(final_in));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/auth_mac.sv
module auth_mac #(
  parameter int W    = 64,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pre_vld,
  input  logic         pre_bit,
  input  logic         msg_bit,
  input  logic         msg_last,
  output logic         msg_take,
  output logic         ct_vld,
  output logic         ct_bit,
  output logic         done,
  output logic [W-1:0] tag
);
  logic load_acc, load_sreg, ks_slot, auth_slot, final_auth;
  logic [W-1:0] sreg_q, sreg_d;
  logic m_q, m_d, ct_q, ct_d, ctv_q, ctv_d;

  auth_mac_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pre_vld    (pre_vld),
    .msg_last   (msg_last),
    .load_acc   (load_acc),
    .load_sreg  (load_sreg),
    .ks_slot    (ks_slot),
    .auth_slot  (auth_slot),
    .final_auth (final_auth)
  );

  auth_mac_acc #(.W(W), .PIPE(PIPE)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .load_en  (load_acc),
    .load_bit (pre_bit),
    .upd_en   (auth_slot & m_q),
    .term_in  (sreg_q),
    .final_in (final_auth),
    .acc      (tag),
    .done     (done)
  );

  assign msg_take = ks_slot;
  assign ct_vld   = ctv_q;
  assign ct_bit   = ct_q;

  always_comb begin
    sreg_d = sreg_q;
    m_d    = m_q;
    ct_d   = ct_q;
    ctv_d  = ks_slot;
    if (load_sreg || auth_slot) sreg_d = {pre_bit, sreg_q[W-1:1]};
    if (ks_slot) begin
      m_d  = msg_bit;
      ct_d = msg_bit ^ pre_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      m_q    <= 1'b0;
      ct_q   <= 1'b0;
      ctv_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      m_q    <= m_d;
      ct_q   <= ct_d;
      ctv_q  <= ctv_d;
    end
  end

  // R4
  ct_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ct_vld |-> $past(msg_take));
  // R8
  sreg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_vld |=> $stable(sreg_q));
endmodule

// File: tb/test_auth_mac.sv
`timescale 1ns/1ps
module test_auth_mac;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n, start, pre_vld, pre_bit, msg_bit, msg_last;
  logic take_p, ctv_p, ct_p, done_p, take_n, ctv_n, ct_n, done_n;
  logic [W-1:0] tag_p, tag_n;

  always #10 clk = ~clk;

  auth_mac #(.W(W), .PIPE(1'b1)) i_auth_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_vld(pre_vld), .pre_bit(pre_bit),
    .msg_bit(msg_bit), .msg_last(msg_last), .msg_take(take_p), .ct_vld(ctv_p),
    .ct_bit(ct_p), .done(done_p), .tag(tag_p));

  auth_mac #(.W(W), .PIPE(1'b0)) i_auth_mac_np (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_vld(pre_vld), .pre_bit(pre_bit),
    .msg_bit(msg_bit), .msg_last(msg_last), .msg_take(take_n), .ct_vld(ctv_n),
    .ct_bit(ct_n), .done(done_n), .tag(tag_n));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // behavioural reference: 0 idle, 1 load, 2 keystream, 3 auth
  int m_ph = 0, m_n = 0;
  bit m_loaded = 1'b0, m_msg = 1'b0, m_last = 1'b0;
  bit [W-1:0] m_acc_n, m_acc_p, m_sr, m_pend;
  bit m_pend_v = 1'b0, m_fin = 1'b0;
  bit e_ctv = 1'b0, e_ct = 1'b0, e_done_n = 1'b0, e_done_p = 1'b0;
  bit hist[$];

  always @(posedge clk) begin
    if (rst_n) begin
      e_ctv = 1'b0; e_done_n = 1'b0;
      e_done_p = m_fin && !start; m_fin = 1'b0;
      if (start) begin
        m_ph = 1; m_n = 0; m_pend_v = 1'b0; m_loaded = 1'b0;
      end else begin
        if (m_pend_v) m_acc_p = m_acc_p ^ m_pend;
        m_pend_v = 1'b0;
        if (pre_vld) begin
          case (m_ph)
            1: begin
              if (m_n < W) begin m_acc_n[m_n] = pre_bit; m_acc_p[m_n] = pre_bit; end
              else m_sr[m_n - W] = pre_bit;
              m_n++;
              if (m_n == 2 * W) begin m_ph = 2; m_loaded = 1'b1; end
            end
            2: begin
              m_msg = msg_bit; m_last = msg_last;
              e_ct = msg_bit ^ pre_bit; e_ctv = 1'b1; m_ph = 3;
            end
            3: begin
              if (m_msg) begin m_acc_n = m_acc_n ^ m_sr; m_pend = m_sr; m_pend_v = 1'b1; end
              m_sr = {pre_bit, m_sr[W-1:1]};
              if (m_last) begin m_ph = 0; e_done_n = 1'b1; m_fin = 1'b1; end
              else m_ph = 2;
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare all outputs against the model (called away from the edge)
  task automatic check_outputs();
    chk(ctv_p == e_ctv && ctv_n == e_ctv, "R4", "ct_vld", {ctv_p, ctv_n}, {e_ctv, e_ctv});
    if (e_ctv) chk(ct_p == e_ct && ct_n == e_ct, "R4", "ct_bit", {ct_p, ct_n}, {e_ct, e_ct});
    chk(done_n == e_done_n, "R11", "done PIPE0", done_n, e_done_n);
    chk(done_p == e_done_p, "R11", "done PIPE1", done_p, e_done_p);
    if (m_loaded || m_ph == 0) begin
      if (m_loaded) begin
        chk(tag_n == m_acc_n, "R5", "tag PIPE0", tag_n, m_acc_n);
        chk(tag_p == m_acc_p, "R5", "tag PIPE1", tag_p, m_acc_p);
      end
    end
  endtask

  // one clock: drive at negedge, feed message if taken, check at next negedge
  task automatic cyc(input bit s, input bit v, input bit b, input bit m, input bit l,
                     output bit took);
    bit e_take;
    start = s; pre_vld = v; pre_bit = b; msg_bit = 1'b0; msg_last = 1'b0;
    #1;
    e_take = (m_ph == 2) && v && !s;
    chk(take_p == e_take && take_n == e_take, "R4", "msg_take", {take_p, take_n}, {e_take, e_take});
    took = e_take;
    if (e_take) begin msg_bit = m; msg_last = l; end
    @(negedge clk);
    check_outputs();
  endtask

  // mode: 0 all zero, 1 single one, 2 random; gap: percent invalid cycles
  task automatic session(input int nmsg, input int mode, input int gap, output int gen_cycles);
    bit took, b, v, mb;
    int k = 0;
    hist.delete();
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, took);   // R9: bit in start cycle ignored
    while (hist.size() < 2 * W) begin
      v = ($urandom_range(99) >= gap); b = $urandom_range(1);
      if (v) hist.push_back(b);
      cyc(1'b0, v, b, 1'b0, 1'b0, took);
    end
    gen_cycles = 0;
    while (m_ph != 0) begin
      v = ($urandom_range(99) >= gap); b = $urandom_range(1);
      mb = (mode == 2) ? bit'($urandom_range(1)) : (mode == 1 && k == 0);
      cyc(1'b0, v, b, mb, k == nmsg - 1, took);
      if (took) k++;
      gen_cycles++;
    end
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, took);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit took;
    int gc;
    logic [W-1:0] first, second;
    void'($urandom(17));
    rst_n = 1'b0; start = 1'b0; pre_vld = 1'b0; pre_bit = 1'b0; msg_bit = 1'b0; msg_last = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ctv_p && !done_p && !take_p && !ctv_n && !done_n && !take_n, "R1", "reset outputs",
        {ctv_p, done_p, take_p}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, took);
    chk(tag_p == 0 && tag_n == 0, "R1", "idle tag", tag_p, 0);

    // R2 and R6: zero message returns first 64 loaded bits; R10 rate
    session(5, 0, 0, gc);
    for (int i = 0; i < W; i++) first[i] = hist[i];
    chk(tag_n == first && tag_p == first, "R2", "zero-message tag", tag_p, first);
    chk(gc == 10, "R10", "gen cycles for 5 bits", gc, 10);

    // R3 and R5: single one folds the unshifted shift register
    session(3, 1, 0, gc);
    for (int i = 0; i < W; i++) begin first[i] = hist[i]; second[i] = hist[W + i]; end
    chk(tag_n == (first ^ second) && tag_p == (first ^ second), "R3", "single-one tag",
        tag_p, first ^ second);
    chk(gc == 6, "R10", "gen cycles for 3 bits", gc, 6);

    // R8: gaps in valid, random messages
    session(20, 2, 40, gc);
    session(1, 2, 0, gc);

    // R9: restart in the middle of generation, then a clean session
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, took);
    for (int i = 0; i < 2 * W + 7; i++) cyc(1'b0, 1'b1, bit'($urandom_range(1)), 1'b1, 1'b0, took);
    session(12, 2, 10, gc);

    // R7: tag held after done, idle ignores bits
    first = tag_p;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, took);
    chk(tag_p == first && !done_p && !ctv_p, "R7", "tag held in idle", tag_p, first);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule